// File: doc/BRIEF.md
# Control Word Loader with BCH Parity Encoder

This block collects a 36-bit control message that arrives as a burst of five byte writes. The first byte lands in the most significant position. The block keeps the upper four bits of the fifth byte and drops its lower four. Once a message is complete, the block moves it into a single transmit buffer. A serial shift register then divides the message by a fixed 12th-degree BCH generator. The 48-bit result, made of the data followed by the 12-bit remainder, is offered to the downstream framing stage through a valid/accept handshake.

Software-side control has three parts: a ready flag, a level interrupt request, and a sticky overrun flag. The block leaves reset powered down and ignores all traffic until its power-down input is cleared. A separate transmit-reset input throws away every message in flight and clears the overrun flag. Transmit reset is used, for example, after a collision is detected on the channel.

Top module: `ctrl_word_encoder`

## Requirements
- R1: While `rstN` is low, or while `powerDown` is high, `rdyFlag`, `irqReq` and `cwValid` are 0. Byte writes during power-down are ignored and do not set `ovrFlag`.
- R2: One clock edge after `powerDown` is seen low in the powered-down state, `rdyFlag` and `irqReq` both read 1.
- R3: The payload is {byte1, byte2, byte3, byte4, byte5[7:4]}, with byte1 most significant. Bits 3:0 of the fifth byte have no effect on the codeword.
- R4: The edge that takes the fifth byte drops `rdyFlag`. On the next edge where the transmit buffer is empty, the word is loaded, and `rdyFlag` and `irqReq` return to 1.
- R5: `cwData` equals {payload[35:0], parity[11:0]}. The parity is the remainder of payload·x^12 divided by x^12+x^10+x^8+x^5+x^4+x^3+1. `cwValid` rises 36 edges after the load edge.
- R6: A high `txReset` at an edge clears `rdyFlag`, `irqReq`, `ovrFlag`, `cwValid` and any partly written message. Afterwards the block behaves as it does on leaving power-down.
- R7: A byte write while `rdyFlag` is low and `powerDown` is low is ignored. It sets `ovrFlag`, which stays set until `txReset` or `rstN`.
- R8: The edge that takes the first byte of a message clears `irqReq`.
- R9: While `cwValid` is high and `cwAccept` is low, `cwValid` and `cwData` hold. An edge with both high clears `cwValid`.
- R10: While the transmit buffer still holds an unaccepted or unfinished codeword, a completed message waits with `rdyFlag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| txReset | input | 1 | Synchronous transmit-path reset |
| powerDown | input | 1 | Power-down control, high holds the block idle |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte written |
| rdyFlag | output | 1 | Block can take a byte |
| irqReq | output | 1 | Level interrupt request |
| ovrFlag | output | 1 | Sticky write-overrun flag |
| cwValid | output | 1 | Codeword available |
| cwData | output | 48 | Codeword {data, parity} |
| cwAccept | input | 1 | Downstream takes the codeword |

## Verification
Flag outputs change one edge after the stimulus that causes them. The ready flag rises two edges after the fifth byte when the buffer is free, and the codeword appears 36 edges after that load edge. The bench drives inputs on falling edges and advances a behavioural model on each rising edge, using the same input values the design samples. It compares every output at the following falling edge, so each expected value is checked in the exact cycle it is due. Directed checks also count the cycles from the ready rise to `cwValid` and compare the parity against a long-division result.

// File: rtl/cwe_pkg.sv
package cwe_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 5;
  localparam int DATA_W    = 36;
  localparam int PAR_W     = 12;
  localparam int CW_W      = DATA_W + PAR_W;
  localparam int TOT_W     = NUM_BYTES * BYTE_W;
  localparam int BIDX_W    = $clog2(NUM_BYTES);
  localparam int CNT_W     = $clog2(DATA_W + 1);
  // low-order generator coefficients: x^10 x^8 x^5 x^4 x^3 x^0
  localparam logic [PAR_W-1:0] GEN_POLY = 12'h539;

  typedef enum logic [1:0] {
    ST_DOWN  = 2'd0,
    ST_READY = 2'd1,
    ST_XFER  = 2'd2
  } ctrl_state_e;

  typedef struct packed {
    logic              clear;
    logic              storeByte;
    logic [BIDX_W-1:0] byteIdx;
    logic              load;
    logic              shift;
    logic [CNT_W-1:0]  bitIdx;
  } enc_strobe_t;
endpackage

// File: rtl/cwe_ctrl.sv
module cwe_ctrl
  import cwe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txReset,
  input  logic        powerDown,
  input  logic        wrEn,
  input  logic        cwAccept,
  output logic        rdyFlag,
  output logic        irqReq,
  output logic        ovrFlag,
  output logic        cwValid,
  output enc_strobe_t strobes
);
  localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(NUM_BYTES - 1);

  ctrl_state_e      state;
  logic [BIDX_W-1:0] byteCnt;
  logic [CNT_W-1:0]  encCnt;
  logic              irqQ, ovrQ, validQ;
  logic              clearAll, bufFree;

  assign clearAll = !rstN || txReset;
  assign bufFree  = (encCnt == '0) && !validQ;

  always_ff @(posedge clk) begin
    if (clearAll) begin
      state   <= ST_DOWN;
      byteCnt <= '0;
      encCnt  <= '0;
      irqQ    <= 1'b0;
      ovrQ    <= 1'b0;
      validQ  <= 1'b0;
    end else if (powerDown) begin
      state   <= ST_DOWN;
      byteCnt <= '0;
      encCnt  <= '0;
      irqQ    <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      if (encCnt != '0) begin
        encCnt <= encCnt - CNT_W'(1);
        if (encCnt == CNT_W'(1)) validQ <= 1'b1;
      end else if (validQ && cwAccept) begin
        validQ <= 1'b0;
      end
      case (state)
        ST_DOWN: begin
          if (wrEn) ovrQ <= 1'b1;
          state <= ST_READY;
          irqQ  <= 1'b1;
        end
        ST_READY: begin
          if (wrEn) begin
            if (byteCnt == '0) irqQ <= 1'b0;
            if (byteCnt == LAST_IDX) begin
              byteCnt <= '0;
              state   <= ST_XFER;
            end else begin
              byteCnt <= byteCnt + BIDX_W'(1);
            end
          end
        end
        ST_XFER: begin
          if (wrEn) ovrQ <= 1'b1;
          if (bufFree) begin
            encCnt <= CNT_W'(DATA_W);
            state  <= ST_READY;
            irqQ   <= 1'b1;
          end
        end
        default: state <= ST_DOWN;
      endcase
    end
  end

  always_comb begin
    strobes.clear     = clearAll || powerDown;
    strobes.storeByte = (state == ST_READY) && wrEn && !strobes.clear;
    strobes.byteIdx   = byteCnt;
    strobes.load      = (state == ST_XFER) && bufFree && !strobes.clear;
    strobes.shift     = (encCnt != '0) && !strobes.clear;
    strobes.bitIdx    = encCnt - CNT_W'(1);
  end

  assign rdyFlag = (state == ST_READY);
  assign irqReq  = irqQ;
  assign ovrFlag = ovrQ;
  assign cwValid = validQ;

  assert_pd_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!rdyFlag && !irqReq && !cwValid));
  assert_txreset_R6: assert property (@(posedge clk) disable iff (!rstN)
    txReset |=> (!rdyFlag && !irqReq && !ovrFlag && !cwValid));
  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdyFlag && !powerDown && !txReset) |=> ovrFlag);
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.storeByte && byteCnt == '0) |=> !irqReq);
  assert_load_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (rdyFlag && irqReq));
  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cwValid && !cwAccept && !powerDown && !txReset) |=> cwValid);
  assert_busy_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && !bufFree && !powerDown && !txReset) |=> !rdyFlag);
endmodule

// File: rtl/cwe_datapath.sv
module cwe_datapath
  import cwe_pkg::*;
#(
  parameter logic [PAR_W-1:0] POLY = GEN_POLY
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BYTE_W-1:0] wrData,
  input  enc_strobe_t     strobes,
  output logic [CW_W-1:0] codeword
);
  logic [BYTE_W-1:0] byteReg [NUM_BYTES];
  logic [TOT_W-1:0]  fullMsg;
  logic [DATA_W-1:0] payload, dataReg;
  logic [PAR_W-1:0]  lfsr;
  logic              fbBit;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (strobes.storeByte && strobes.byteIdx == BIDX_W'(i))
        byteReg[i] <= wrData;
    end
  end

  always_comb begin
    fullMsg = '0;
    for (int i = 0; i < NUM_BYTES; i++)
      fullMsg[(NUM_BYTES-1-i)*BYTE_W +: BYTE_W] = byteReg[i];
    payload = fullMsg[TOT_W-1 -: DATA_W];
  end

  assign fbBit = dataReg[strobes.bitIdx] ^ lfsr[PAR_W-1];

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      dataReg <= '0;
      lfsr    <= '0;
    end else if (strobes.load) begin
      dataReg <= payload;
      lfsr    <= '0;
    end else if (strobes.shift) begin
      lfsr <= {lfsr[PAR_W-2:0], 1'b0} ^ ({PAR_W{fbBit}} & POLY);
    end
  end

  assign codeword = {dataReg, lfsr};

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> !strobes.shift);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.shift && !strobes.clear) |=> $stable(codeword));
endmodule

// File: rtl/ctrl_word_encoder.sv
module ctrl_word_encoder
  import cwe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txReset,
  input  logic              powerDown,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic              rdyFlag,
  output logic              irqReq,
  output logic              ovrFlag,
  output logic              cwValid,
  output logic [CW_W-1:0]   cwData,
  input  logic              cwAccept
);
  enc_strobe_t strobes;

  cwe_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .txReset(txReset), .powerDown(powerDown),
    .wrEn(wrEn), .cwAccept(cwAccept), .rdyFlag(rdyFlag), .irqReq(irqReq),
    .ovrFlag(ovrFlag), .cwValid(cwValid), .strobes(strobes)
  );

  cwe_datapath #(.POLY(GEN_POLY)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobes(strobes),
    .codeword(cwData)
  );
endmodule

// File: tb/ctrl_word_encoder_tb_top.sv
module ctrl_word_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0, txReset = 1'b0, powerDown = 1'b1;
  logic        wrEn = 1'b0, cwAccept = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdyFlag, irqReq, ovrFlag, cwValid;
  logic [47:0] cwData;

  int nVec = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctrl_word_encoder dut_i (
    .clk(clk), .rstN(rstN), .txReset(txReset), .powerDown(powerDown),
    .wrEn(wrEn), .wrData(wrData), .rdyFlag(rdyFlag), .irqReq(irqReq),
    .ovrFlag(ovrFlag), .cwValid(cwValid), .cwData(cwData), .cwAccept(cwAccept)
  );

  // long-division encoder, independent of any shift structure
  function automatic logic [47:0] encode(logic [35:0] d);
    logic [47:0] r = {d, 12'b0};
    for (int i = 47; i >= 12; i--)
      if (r[i]) r = r ^ (48'h1539 << (i - 12));
    return {d, r[11:0]};
  endfunction

  task automatic chk(string tag, string what, logic [47:0] act, logic [47:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int          mState = 0, mCnt = 0, mEnc = 0;
  bit          mValid = 0, mIrq = 0, mOvr = 0;
  logic [7:0]  mB [5];
  logic [47:0] mCode = '0;

  always @(posedge clk) begin
    bit freeB;
    if (!rstN || txReset) begin
      mState = 0; mCnt = 0; mEnc = 0; mValid = 0; mIrq = 0; mOvr = 0;
    end else if (powerDown) begin
      mState = 0; mCnt = 0; mEnc = 0; mValid = 0; mIrq = 0;
    end else begin
      freeB = (mEnc == 0) && !mValid;
      if (mEnc > 0) begin
        mEnc--;
        if (mEnc == 0) mValid = 1;
      end else if (mValid && cwAccept) mValid = 0;
      case (mState)
        0: begin if (wrEn) mOvr = 1; mState = 1; mIrq = 1; end
        1: if (wrEn) begin
             mB[mCnt] = wrData;
             if (mCnt == 0) mIrq = 0;
             mCnt++;
             if (mCnt == 5) begin mCnt = 0; mState = 2; end
           end
        default: begin
          if (wrEn) mOvr = 1;
          if (freeB) begin
            mCode = encode({mB[0], mB[1], mB[2], mB[3], mB[4][7:4]});
            mEnc = 36; mState = 1; mIrq = 1;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4", "rdyFlag model", rdyFlag, 48'(mState == 1));
      chk("R8", "irqReq model", irqReq, 48'(mIrq));
      chk("R7", "ovrFlag model", ovrFlag, 48'(mOvr));
      chk("R9", "cwValid model", cwValid, 48'(mValid));
      if (mValid) chk("R5", "cwData model", cwData, mCode);
    end
  end

  task automatic sendMsg(logic [39:0] m);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrData = m[39 - 8*i -: 8];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitValid(output int n);
    n = 0;
    while (!cwValid && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic acceptCw();
    cwAccept = 1'b1;
    @(negedge clk);
    cwAccept = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    int n;
    logic [47:0] cwA;
    repeat (3) @(negedge clk);
    chk("R1", "rdy in reset", rdyFlag, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "rdy in power-down", rdyFlag, 0);
    chk("R1", "irq in power-down", irqReq, 0);
    wrEn = 1'b1; wrData = 8'h5A;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R1", "ovr after power-down write", ovrFlag, 0);
    chk("R1", "valid in power-down", cwValid, 0);

    powerDown = 1'b0;
    @(negedge clk);
    chk("R2", "rdy after wake", rdyFlag, 1);
    chk("R2", "irq after wake", irqReq, 1);

    // known vector: payload 1 gives the generator's low coefficients
    @(negedge clk); wrEn = 1'b1; wrData = 8'h00;
    @(negedge clk);
    chk("R8", "irq after first byte", irqReq, 0);
    wrData = 8'h00; @(negedge clk); wrData = 8'h00; @(negedge clk);
    wrData = 8'h00; @(negedge clk); wrData = 8'h10; @(negedge clk);
    wrEn = 1'b0;
    chk("R4", "rdy after fifth byte", rdyFlag, 0);
    @(negedge clk);
    chk("R4", "rdy after load", rdyFlag, 1);
    chk("R4", "irq after load", irqReq, 1);
    waitValid(n);
    chk("R5", "cycles load to valid", 48'(n), 48'd36);
    chk("R5", "parity of payload 1", cwData, {36'h1, 12'h539});
    repeat (3) @(negedge clk);
    chk("R9", "valid held", cwValid, 1);
    chk("R9", "data held", cwData, {36'h1, 12'h539});
    acceptCw();
    chk("R9", "valid after accept", cwValid, 0);

    // R3: low nibble of last byte has no effect
    sendMsg(40'h123456789A);
    waitValid(n);
    cwA = cwData;
    chk("R3", "data field", cwData[47:12], 36'h123456789);
    chk("R5", "parity msg A", cwData, encode(36'h123456789));
    acceptCw();
    sendMsg(40'h123456789F);
    waitValid(n);
    chk("R3", "codeword ignores nibble", cwData, cwA);

    // R10 / R7: second message while buffer occupied
    sendMsg(40'hA5C33C5AF0);
    repeat (3) @(negedge clk);
    chk("R10", "rdy while buffer busy", rdyFlag, 0);
    wrEn = 1'b1; wrData = 8'hEE;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R7", "overrun set", ovrFlag, 1);
    acceptCw();
    @(negedge clk);
    chk("R10", "rdy after buffer freed", rdyFlag, 1);
    waitValid(n);
    chk("R5", "queued codeword", cwData, encode(36'hA5C33C5AF));
    acceptCw();

    // R6: transmit reset mid-message
    @(negedge clk); wrEn = 1'b1; wrData = 8'h77;
    @(negedge clk); wrData = 8'h88;
    @(negedge clk); wrEn = 1'b0; txReset = 1'b1;
    @(negedge clk); txReset = 1'b0;
    chk("R6", "rdy after txReset", rdyFlag, 0);
    chk("R6", "ovr after txReset", ovrFlag, 0);
    @(negedge clk);
    chk("R6", "irq after recovery", irqReq, 1);
    sendMsg(40'h0F1E2D3C4B);
    waitValid(n);
    chk("R6", "fresh codeword", cwData, encode(36'h0F1E2D3C4));
    acceptCw();

    // R1: power-down mid-message
    @(negedge clk); wrEn = 1'b1; wrData = 8'h11;
    @(negedge clk); wrEn = 1'b0; powerDown = 1'b1;
    @(negedge clk);
    chk("R1", "rdy after power-down", rdyFlag, 0);
    powerDown = 1'b0;
    @(negedge clk);
    sendMsg(40'hFFFFFFFFF0);
    waitValid(n);
    chk("R5", "all-ones payload", cwData, encode(36'hFFFFFFFFF));
    acceptCw();
    repeat (2) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule